// File: doc/BRIEF.md
# Character Row Bitmap Fetch Unit

This block turns a character code, a pixel-row index and a font-height select into an address for a 64-byte writable glyph memory. It returns the five-pixel pattern of that row one clock later. Two glyph heights are supported. The short font uses eight rows per glyph slot and the tall font uses eleven rows. Each height folds the character code into the address in its own way, so some code bits select nothing and several codes alias to one glyph.

When the character being drawn sits at the cursor position, the unit can light the glyph's bottom row as an underline cursor. It can also force the whole glyph on during the active blink phase.

A host port writes and reads the same memory a byte at a time. The three upper bits of each byte are kept for the host, and the display path never uses them. Display fetches are never held up. A host access is carried out only in a cycle with no fetch request, and the unit grants it in that same cycle.

Top module: `glyph_row_fetch`

## Requirements
- R1: With tallFont low, a fetch reads byte address {charCode[2:0], rowIdx[2:0]}. charCode[7:3] and rowIdx[3] have no effect, so codes 0x00 and 0x08 return the same row.
- R2: With tallFont high, a fetch reads byte address {charCode[2:1], rowIdx[3:0]}. charCode[7:3] and charCode[0] have no effect, so codes 0x00, 0x01, 0x08 and 0x09 return the same row.
- R3: With tallFont high and rowIdx above 10, the returned pattern is 5'b00000. This holds whatever the memory contents, cursor or blink inputs are.
- R4: rowPixels[i] equals bit i of the addressed byte, for i = 0 to 4, with 1 meaning pixel on. Bits 7:5 of the byte never affect rowPixels.
- R5: rowValid is high in exactly the cycle after a cycle with fetchReq high, and rowPixels then carries that fetch's pattern. rowPixels is 0 whenever rowValid is low.
- R6: If cursorOn and atCursor are both high and the row is the bottom row (row 7 for the short font, row 10 for the tall font), the pattern is 5'b11111. The cursor inputs leave every other row unchanged.
- R7: If blinkOn, atCursor and blinkPhase are all high, every displayed row of that fetch returns 5'b11111. If any of the three is low, blinking has no effect.
- R8: With fetchReq low, hostWrEn high stores hostWrData at hostAddr and hostAck is high in that cycle. With fetchReq high, the write is dropped, hostAck is low, and the memory is unchanged.
- R9: With fetchReq and hostWrEn low and hostRdEn high, hostAck is high. The next cycle then has hostRdValid high and hostRdData equal to the full 8-bit byte stored at hostAddr.
- R10: While rstN is low, rowValid and hostRdValid are low and rowPixels is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchReq | input | 1 | Display fetch request |
| charCode | input | 8 | Character code to draw |
| rowIdx | input | 4 | Pixel row, 0 is the top row |
| tallFont | input | 1 | 1 selects the tall font (11 rows), 0 the short font (8 rows) |
| cursorOn | input | 1 | Underline cursor enable |
| blinkOn | input | 1 | Blink enable |
| atCursor | input | 1 | Character is at the cursor position |
| blinkPhase | input | 1 | Blink phase, 1 means lit |
| hostWrEn | input | 1 | Host write request |
| hostRdEn | input | 1 | Host read request |
| hostAddr | input | 6 | Host byte address |
| hostWrData | input | 8 | Host write data |
| hostAck | output | 1 | Host access granted this cycle |
| hostRdData | output | 8 | Host read data |
| hostRdValid | output | 1 | hostRdData is valid |
| rowPixels | output | 5 | Row pixel pattern |
| rowValid | output | 1 | rowPixels is valid |

## Verification
The assertions assume that every input is a known value at each rising edge. They also assume that a host requester holds its request until hostAck shows, because a dropped write is never replayed. The bench drives every input on the falling edge. It never leaves a control input undriven after reset, and it checks hostAck before it treats an access as done. The sweeps run back-to-back fetches across all sixteen row indices and all low code patterns in both font heights. The aliasing high code bits are varied on every fetch, so the checks cover the bits that must be ignored.

// File: rtl/glyph_fetch_pkg.sv
package glyph_fetch_pkg;

  // Strobes from the control module to the datapath for one cycle.
  typedef struct packed {
    logic ramWe;    // host byte write
    logic ramRd;    // memory read port enabled
    logic fetchRd;  // read belongs to a display fetch
    logic hostRd;   // read belongs to the host
  } fetchStrb_t;

endpackage

// File: rtl/glyph_fetch_ctrl.sv
module glyph_fetch_ctrl
  import glyph_fetch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fetchReq,
  input  logic       hostWrEn,
  input  logic       hostRdEn,
  output fetchStrb_t strb,
  output logic       hostAck,
  output logic       rowValid,
  output logic       hostRdValid
);

  logic hostSlot;

  // The display path owns every cycle with a fetch; the host gets the rest.
  always_comb begin
    hostSlot     = ~fetchReq;
    strb.fetchRd = fetchReq;
    strb.ramWe   = hostWrEn & hostSlot;
    strb.hostRd  = hostRdEn & ~hostWrEn & hostSlot;
    strb.ramRd   = fetchReq | strb.hostRd;
    hostAck      = strb.ramWe | strb.hostRd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowValid    <= 1'b0;
      hostRdValid <= 1'b0;
    end else begin
      rowValid    <= strb.fetchRd;
      hostRdValid <= strb.hostRd;
    end
  end

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN) fetchReq |=> rowValid) else $error("rowValid missing"); // R5
  AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN) $rose(rowValid) |-> $past(fetchReq)) else $error("spurious rowValid"); // R5
  AST_HOST_YIELDS: assert property (@(posedge clk) disable iff (!rstN) fetchReq |-> (!strb.ramWe && !hostAck)) else $error("host won over fetch"); // R8
  AST_RD_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rstN) (hostRdEn && !hostWrEn && !fetchReq) |=> hostRdValid) else $error("host read lost"); // R9
  AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN) $onehot0({strb.ramWe, strb.fetchRd, strb.hostRd})) else $error("port overlap"); // R8
  AST_NO_DUAL_VALID: assert property (@(posedge clk) disable iff (!rstN) !(rowValid && hostRdValid)) else $error("both valids"); // R9

endmodule

// File: rtl/glyph_fetch_dp.sv
module glyph_fetch_dp
  import glyph_fetch_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int ROW_W      = 4,
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 8,
  parameter int PIX_W      = 5,
  parameter int SHORT_ROWS = 8,
  parameter int TALL_ROWS  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  fetchStrb_t        strb,
  input  logic              rowValid,
  input  logic [CODE_W-1:0] charCode,
  input  logic [ROW_W-1:0]  rowIdx,
  input  logic              tallFont,
  input  logic              cursorOn,
  input  logic              blinkOn,
  input  logic              atCursor,
  input  logic              blinkPhase,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [PIX_W-1:0]  rowPixels,
  output logic [DATA_W-1:0] hostRdData
);

  localparam int DEPTH    = 1 << ADDR_W;
  localparam int SHORT_RB = $clog2(SHORT_ROWS);
  localparam int TALL_RB  = $clog2(TALL_ROWS);
  localparam int SHORT_CB = ADDR_W - SHORT_RB;
  localparam int TALL_CB  = ADDR_W - TALL_RB;
  localparam logic [SHORT_RB-1:0] SHORT_BOT = SHORT_RB'(SHORT_ROWS - 1);
  localparam logic [ROW_W-1:0]    TALL_BOT  = ROW_W'(TALL_ROWS - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] ramQ;
  logic [ADDR_W-1:0] shortAddr, tallAddr, fetchAddr, ramAddr;
  logic              isBottom, outOfRange, forceNext;
  logic              forceOn, blankRow;
  logic              unusedBits;

  // The tall font drops code bit 0 and takes one more row bit.
  always_comb begin
    shortAddr  = {charCode[SHORT_CB-1:0], rowIdx[SHORT_RB-1:0]};
    tallAddr   = {charCode[TALL_CB:1], rowIdx[TALL_RB-1:0]};
    fetchAddr  = tallFont ? tallAddr : shortAddr;
    ramAddr    = strb.fetchRd ? fetchAddr : hostAddr;
    isBottom   = tallFont ? (rowIdx == TALL_BOT) : (rowIdx[SHORT_RB-1:0] == SHORT_BOT);
    outOfRange = tallFont && (rowIdx > TALL_BOT);
    forceNext  = atCursor & ((cursorOn & isBottom) | (blinkOn & blinkPhase));
  end

  assign unusedBits = ^{charCode[CODE_W-1:SHORT_CB], strb.hostRd};

  always_ff @(posedge clk) begin
    if (strb.ramWe) mem[hostAddr] <= hostWrData;
    if (strb.ramRd) ramQ <= mem[ramAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      forceOn  <= 1'b0;
      blankRow <= 1'b0;
    end else if (strb.fetchRd) begin
      forceOn  <= forceNext;
      blankRow <= outOfRange;
    end
  end

  for (genvar g = 0; g < PIX_W; g++) begin : gPix
    assign rowPixels[g] = rowValid & ~blankRow & (ramQ[g] | forceOn);
  end

  assign hostRdData = ramQ;

  AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rstN) !rowValid |-> (rowPixels == '0)) else $error("pixels while idle"); // R5
  AST_TALL_BLANK: assert property (@(posedge clk) disable iff (!rstN) (strb.fetchRd && tallFont && rowIdx > TALL_BOT) |=> (rowPixels == '0)) else $error("row beyond glyph lit"); // R3
  AST_BLINK_LIT: assert property (@(posedge clk) disable iff (!rstN) (strb.fetchRd && !outOfRange && blinkOn && atCursor && blinkPhase) |=> (rowPixels == '1)) else $error("blink not lit"); // R7
  AST_CURSOR_LIT: assert property (@(posedge clk) disable iff (!rstN) (strb.fetchRd && cursorOn && atCursor && isBottom) |=> (rowPixels == '1)) else $error("cursor row not lit"); // R6

endmodule

// File: rtl/glyph_row_fetch.sv
module glyph_row_fetch
  import glyph_fetch_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int ROW_W  = 4,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int PIX_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchReq,
  input  logic [CODE_W-1:0] charCode,
  input  logic [ROW_W-1:0]  rowIdx,
  input  logic              tallFont,
  input  logic              cursorOn,
  input  logic              blinkOn,
  input  logic              atCursor,
  input  logic              blinkPhase,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic              hostAck,
  output logic [DATA_W-1:0] hostRdData,
  output logic              hostRdValid,
  output logic [PIX_W-1:0]  rowPixels,
  output logic              rowValid
);

  fetchStrb_t strb;

  glyph_fetch_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .fetchReq    (fetchReq),
    .hostWrEn    (hostWrEn),
    .hostRdEn    (hostRdEn),
    .strb        (strb),
    .hostAck     (hostAck),
    .rowValid    (rowValid),
    .hostRdValid (hostRdValid)
  );

  glyph_fetch_dp #(
    .CODE_W (CODE_W),
    .ROW_W  (ROW_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PIX_W  (PIX_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .rowValid   (rowValid),
    .charCode   (charCode),
    .rowIdx     (rowIdx),
    .tallFont   (tallFont),
    .cursorOn   (cursorOn),
    .blinkOn    (blinkOn),
    .atCursor   (atCursor),
    .blinkPhase (blinkPhase),
    .hostAddr   (hostAddr),
    .hostWrData (hostWrData),
    .rowPixels  (rowPixels),
    .hostRdData (hostRdData)
  );

endmodule

// File: tb/glyph_row_fetch_tb.sv
`timescale 1ns/1ps
module glyph_row_fetch_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fetchReq = 1'b0;
  logic [7:0] charCode = '0;
  logic [3:0] rowIdx = '0;
  logic       tallFont = 1'b0, cursorOn = 1'b0, blinkOn = 1'b0;
  logic       atCursor = 1'b0, blinkPhase = 1'b0;
  logic       hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [5:0] hostAddr = '0;
  logic [7:0] hostWrData = '0;
  logic       hostAck, hostRdValid, rowValid;
  logic [7:0] hostRdData;
  logic [4:0] rowPixels;

  logic [7:0] model [64];
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  glyph_row_fetch u_dut (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .charCode(charCode),
    .rowIdx(rowIdx), .tallFont(tallFont), .cursorOn(cursorOn),
    .blinkOn(blinkOn), .atCursor(atCursor), .blinkPhase(blinkPhase),
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostAck(hostAck), .hostRdData(hostRdData),
    .hostRdValid(hostRdValid), .rowPixels(rowPixels), .rowValid(rowValid)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] expPix(input logic [7:0] code, input int row,
      input bit tall, input bit cur, input bit blk, input bit atc, input bit ph);
    logic [5:0] a;
    logic [4:0] p;
    bit bottom;
    if (tall && row > 10) return 5'd0;
    a = tall ? {code[2:1], 4'(row)} : {code[2:0], 3'(row)};
    p = model[a][4:0];
    bottom = tall ? (row == 10) : ((row % 8) == 7);
    if (cur && atc && bottom) p = 5'h1f;
    if (blk && atc && ph) p = 5'h1f;
    return p;
  endfunction

  task automatic hostWrite(input int a, input logic [7:0] d, input string tag);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = 6'(a); hostWrData = d;
    #1 check(hostAck === 1'b1, tag, int'(hostAck), 1);
    model[a] = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input int a, input string tag);
    @(negedge clk);
    hostRdEn = 1'b1; hostAddr = 6'(a);
    @(negedge clk);
    hostRdEn = 1'b0;
    check(hostRdValid === 1'b1 && hostRdData === model[a], tag,
          int'({hostRdValid, hostRdData}), int'({1'b1, model[a]}));
  endtask

  // Back-to-back fetches over every low code pattern and every row index.
  task automatic sweep(input string tag, input bit tall, input bit cur,
      input bit blk, input bit atc, input bit ph);
    bit pend = 1'b0;
    logic [4:0] pexp = '0;
    string ptag = tag;
    logic [7:0] code;
    tallFont = tall; cursorOn = cur; blinkOn = blk; atCursor = atc; blinkPhase = ph;
    for (int c = 0; c < 16; c++) begin
      for (int r = 0; r < 16; r++) begin
        @(negedge clk);
        if (pend) check(rowValid === 1'b1 && rowPixels === pexp, ptag,
                        int'({rowValid, rowPixels}), int'({1'b1, pexp}));
        code = {4'((c * 5 + r * 3) & 15), 4'(c)};
        fetchReq = 1'b1; charCode = code; rowIdx = 4'(r);
        pexp = expPix(code, r, tall, cur, blk, atc, ph);
        ptag = (tall && r > 10) ? "R3" : tag;
        pend = 1'b1;
      end
    end
    @(negedge clk);
    check(rowValid === 1'b1 && rowPixels === pexp, ptag,
          int'({rowValid, rowPixels}), int'({1'b1, pexp}));
    fetchReq = 1'b0;
    @(negedge clk);
    check(rowValid === 1'b0 && rowPixels === 5'd0, "R5",
          int'({rowValid, rowPixels}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rowValid === 1'b0 && hostRdValid === 1'b0 && rowPixels === 5'd0, "R10",
          int'({rowValid, hostRdValid, rowPixels}), 0);
    rstN = 1'b1;

    for (int a = 0; a < 64; a++) hostWrite(a, 8'((a * 37 + 11) & 255), "R8");
    for (int a = 0; a < 64; a++) hostRead(a, "R9");

    // Upper data bits must not reach the pixels.
    hostWrite(0, 8'hEA, "R4");
    @(negedge clk);
    fetchReq = 1'b1; charCode = 8'h00; rowIdx = 4'd0; tallFont = 1'b0;
    @(negedge clk);
    fetchReq = 1'b0;
    check(rowValid === 1'b1 && rowPixels === 5'h0A, "R4", int'(rowPixels), 'h0A);
    hostRead(0, "R9");

    // A write during a fetch is dropped.
    @(negedge clk);
    fetchReq = 1'b1; hostWrEn = 1'b1; hostAddr = 6'd5; hostWrData = ~model[5];
    #1 check(hostAck === 1'b0, "R8", int'(hostAck), 0);
    @(negedge clk);
    fetchReq = 1'b0; hostWrEn = 1'b0;
    hostRead(5, "R8");

    sweep("R1", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    sweep("R2", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    sweep("R6", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    sweep("R6", 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    sweep("R6", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    sweep("R7", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    sweep("R7", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    sweep("R7", 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule